// File: doc/BRIEF.md
# Torus Adaptive Route and Virtual Channel Selector

This block is the route computation stage of a router in a two-dimensional torus with east, west, north and south links plus a local ejection port. For each packet header it is given the current node coordinates, the destination coordinates, the packet class, an I/O flag, two per-dimension wraparound history bits, and the occupancy of every class's adaptive buffer at every neighbour. It returns the output port, the virtual channel and the updated wraparound history bits. The result is registered and appears one clock after the header is presented.

Non-I/O packets prefer a per-class adaptive channel. They may take either minimal direction, and the one with less queued traffic wins. When no adaptive buffer on a minimal direction has room, or the packet is an I/O packet, the packet drops onto the deadlock-free escape channels. These route fully along X before Y. In each dimension two escape channels are used: one before the packet has crossed the ring's wraparound link and one after, which breaks the ring's cyclic dependency.

Buffering, credit return and switch arbitration live in neighbouring stages. This block only decides where a header goes.

Top module: `torus_route_sel`

## Requirements
- R1: While rst_ni is low, valid_o, port_o, vc_o, wrap_x_o and wrap_y_o are all 0.
- R2: valid_o equals valid_i from the previous clock. Every result belongs to the header presented on the previous clock.
- R3: Per dimension of ring size K, let f = (dst - cur) mod K. If f is 0 the dimension is finished. Otherwise the only allowed direction is positive when 2f <= K (a tie picks positive) and negative when 2f > K. Port codes: 0 local, 1 east (+X), 2 west (-X), 3 north (+Y), 4 south (-Y).
- R4: When the current and destination coordinates match, port_o is 0 (local), vc_o is 0, and the wraparound bits pass through unchanged.
- R5: A direction is an adaptive candidate when it is allowed by R3 and the occupancy of the packet's class in that direction is below ADAPT_DEPTH. That occupancy is the OCC_W-bit field at bit ((d*NUM_CLASS)+class)*OCC_W of adapt_occ_i, with d = 0 east, 1 west, 2 north, 3 south. A packet routed adaptively gets vc_o = 2.
- R6: With two adaptive candidates, the one with lower occupancy wins. Equal occupancy picks the X direction.
- R7: An I/O packet (io_i = 1) never gets vc_o = 2, whatever the occupancy.
- R8: Without an adaptive candidate, or for an I/O packet, the packet moves in X while X is unfinished and only then in Y.
- R9: On an escape hop, vc_o is 1 when that dimension's wraparound input bit is set or when the hop itself crosses the wraparound link. Crossing hops are east from X = X_SIZE-1, west from X = 0, north from Y = Y_SIZE-1 and south from Y = 0. Otherwise vc_o is 0.
- R10: wrap_x_o is wrap_x_i OR (the hop is in X and crosses the wraparound link), on either channel type. wrap_y_o follows the same rule for Y.
- R11: Occupancy fields of other classes have no effect on the chosen port or channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Header present this cycle |
| cur_x_i | input | XW | Current node X |
| cur_y_i | input | YW | Current node Y |
| dst_x_i | input | XW | Destination X |
| dst_y_i | input | YW | Destination Y |
| class_i | input | CLS_W | Packet class |
| io_i | input | 1 | Packet is I/O traffic |
| wrap_x_i | input | 1 | Packet has already crossed the X wraparound |
| wrap_y_i | input | 1 | Packet has already crossed the Y wraparound |
| adapt_occ_i | input | 4*NUM_CLASS*OCC_W | Adaptive buffer occupancy per direction and class |
| valid_o | output | 1 | Result valid |
| port_o | output | 3 | Output port code |
| vc_o | output | 2 | 0 escape low, 1 escape high, 2 adaptive |
| wrap_x_o | output | 1 | Updated X wraparound bit |
| wrap_y_o | output | 1 | Updated Y wraparound bit |

## Verification
Every output is due exactly one rising edge after the header is driven. The bench applies each header on a falling edge and reads port, channel, wraparound bits and valid on the next falling edge, one full registered stage later. The expected values come from a bench model that is evaluated on the same header values. Directed headers cover the tie distance, wraparound hops, equal occupancy, I/O packets, full buffers of other classes and a dropped valid. A seeded random run over coordinates, classes and occupancies follows.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;
  localparam int NUM_DIRS = 4;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    VC_ESC_LO = 2'd0,
    VC_ESC_HI = 2'd1,
    VC_ADAPT  = 2'd2
  } vc_e;

  // per-dimension minimal hop info
  typedef struct packed {
    logic prod;  // dimension unfinished
    logic pos;   // positive direction
    logic wrap;  // hop crosses the wraparound link
  } ring_hop_t;
endpackage

// File: rtl/torus_ring_dir.sv
module torus_ring_dir
  import torus_rt_pkg::*;
#(
  parameter int RING = 4,
  parameter int CW   = (RING > 1) ? $clog2(RING) : 1
) (
  input  logic [CW-1:0] cur_i,
  input  logic [CW-1:0] dst_i,
  output ring_hop_t     hop_o
);
  localparam int FW = CW + 2;

  logic [FW-1:0] cur_w, dst_w, fwd;

  assign cur_w = FW'(cur_i);
  assign dst_w = FW'(dst_i);

  always_comb begin
    if (dst_w >= cur_w) fwd = dst_w - cur_w;
    else                fwd = dst_w + FW'(RING) - cur_w;
  end

  assign hop_o.prod = (fwd != '0);
  assign hop_o.pos  = ((fwd << 1) <= FW'(RING));
  assign hop_o.wrap = hop_o.pos ? (cur_i == CW'(RING - 1)) : (cur_i == '0);
endmodule

// File: rtl/torus_adapt_pick.sv
module torus_adapt_pick
  import torus_rt_pkg::*;
#(
  parameter int NUM_CLASS   = 4,
  parameter int OCC_W       = 3,
  parameter int ADAPT_DEPTH = 4,
  parameter int CLS_W       = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1,
  parameter int OCCV_W      = NUM_DIRS * NUM_CLASS * OCC_W
) (
  input  ring_hop_t          hop_x_i,
  input  ring_hop_t          hop_y_i,
  input  logic               io_i,
  input  logic [CLS_W-1:0]   class_i,
  input  logic [OCCV_W-1:0]  occ_i,
  output logic               use_o,
  output logic               dim_y_o
);
  logic [OCC_W-1:0] occ_dir [NUM_DIRS];
  logic [OCC_W-1:0] occ_x, occ_y;
  logic             cand_x, cand_y;

  always_comb begin
    for (int d = 0; d < NUM_DIRS; d++) begin
      occ_dir[d] = occ_i[(d * NUM_CLASS + int'(class_i)) * OCC_W +: OCC_W];
    end
  end

  assign occ_x  = hop_x_i.pos ? occ_dir[0] : occ_dir[1];
  assign occ_y  = hop_y_i.pos ? occ_dir[2] : occ_dir[3];
  assign cand_x = hop_x_i.prod && (occ_x < OCC_W'(ADAPT_DEPTH));
  assign cand_y = hop_y_i.prod && (occ_y < OCC_W'(ADAPT_DEPTH));

  assign use_o   = !io_i && (cand_x || cand_y);
  // tie keeps X
  assign dim_y_o = cand_y && (!cand_x || (occ_y < occ_x));
endmodule

// File: rtl/torus_escape_pick.sv
module torus_escape_pick
  import torus_rt_pkg::*;
(
  input  ring_hop_t hop_x_i,
  input  ring_hop_t hop_y_i,
  input  logic      wrap_x_i,
  input  logic      wrap_y_i,
  output logic      local_o,
  output logic      dim_y_o,
  output logic      vc_hi_o
);
  assign local_o = !hop_x_i.prod && !hop_y_i.prod;
  assign dim_y_o = !hop_x_i.prod;

  always_comb begin
    if (local_o)      vc_hi_o = 1'b0;
    else if (dim_y_o) vc_hi_o = wrap_y_i | hop_y_i.wrap;
    else              vc_hi_o = wrap_x_i | hop_x_i.wrap;
  end
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
  import torus_rt_pkg::*;
#(
  parameter int X_SIZE      = 4,
  parameter int Y_SIZE      = 4,
  parameter int NUM_CLASS   = 4,
  parameter int ADAPT_DEPTH = 4,
  parameter int OCC_W       = 3,
  parameter int XW          = (X_SIZE > 1) ? $clog2(X_SIZE) : 1,
  parameter int YW          = (Y_SIZE > 1) ? $clog2(Y_SIZE) : 1,
  parameter int CLS_W       = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1,
  parameter int OCCV_W      = 4 * NUM_CLASS * OCC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XW-1:0]     cur_x_i,
  input  logic [YW-1:0]     cur_y_i,
  input  logic [XW-1:0]     dst_x_i,
  input  logic [YW-1:0]     dst_y_i,
  input  logic [CLS_W-1:0]  class_i,
  input  logic              io_i,
  input  logic              wrap_x_i,
  input  logic              wrap_y_i,
  input  logic [OCCV_W-1:0] adapt_occ_i,
  output logic              valid_o,
  output logic [2:0]        port_o,
  output logic [1:0]        vc_o,
  output logic              wrap_x_o,
  output logic              wrap_y_o
);
  ring_hop_t hop_x, hop_y;
  logic      ad_use, ad_dim_y;
  logic      es_local, es_dim_y, es_vc_hi;
  logic      dim_y;
  port_e     port_n;
  vc_e       vc_n;
  logic      wrap_x_n, wrap_y_n;

  torus_ring_dir #(.RING(X_SIZE), .CW(XW)) u_ring_x (
    .cur_i (cur_x_i),
    .dst_i (dst_x_i),
    .hop_o (hop_x)
  );

  torus_ring_dir #(.RING(Y_SIZE), .CW(YW)) u_ring_y (
    .cur_i (cur_y_i),
    .dst_i (dst_y_i),
    .hop_o (hop_y)
  );

  torus_adapt_pick #(
    .NUM_CLASS   (NUM_CLASS),
    .OCC_W       (OCC_W),
    .ADAPT_DEPTH (ADAPT_DEPTH),
    .CLS_W       (CLS_W),
    .OCCV_W      (OCCV_W)
  ) u_adapt (
    .hop_x_i (hop_x),
    .hop_y_i (hop_y),
    .io_i    (io_i),
    .class_i (class_i),
    .occ_i   (adapt_occ_i),
    .use_o   (ad_use),
    .dim_y_o (ad_dim_y)
  );

  torus_escape_pick u_escape (
    .hop_x_i  (hop_x),
    .hop_y_i  (hop_y),
    .wrap_x_i (wrap_x_i),
    .wrap_y_i (wrap_y_i),
    .local_o  (es_local),
    .dim_y_o  (es_dim_y),
    .vc_hi_o  (es_vc_hi)
  );

  assign dim_y = ad_use ? ad_dim_y : es_dim_y;

  always_comb begin
    if (es_local) begin
      port_n = PORT_LOCAL;
      vc_n   = VC_ESC_LO;
    end else begin
      if (dim_y) port_n = hop_y.pos ? PORT_NORTH : PORT_SOUTH;
      else       port_n = hop_x.pos ? PORT_EAST  : PORT_WEST;
      if (ad_use)        vc_n = VC_ADAPT;
      else if (es_vc_hi) vc_n = VC_ESC_HI;
      else               vc_n = VC_ESC_LO;
    end
  end

  assign wrap_x_n = wrap_x_i | (!es_local && !dim_y && hop_x.wrap);
  assign wrap_y_n = wrap_y_i | (!es_local &&  dim_y && hop_y.wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      port_o   <= '0;
      vc_o     <= '0;
      wrap_x_o <= 1'b0;
      wrap_y_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        port_o   <= port_n;
        vc_o     <= vc_n;
        wrap_x_o <= wrap_x_n;
        wrap_y_o <= wrap_y_n;
      end
    end
  end
endmodule

// File: rtl/torus_route_sel_chk.sv
module torus_route_sel_chk #(
  parameter int X_SIZE      = 4,
  parameter int Y_SIZE      = 4,
  parameter int NUM_CLASS   = 4,
  parameter int ADAPT_DEPTH = 4,
  parameter int OCC_W       = 3,
  parameter int XW          = 2,
  parameter int YW          = 2,
  parameter int CLS_W       = 2,
  parameter int OCCV_W      = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [XW-1:0]     cur_x_i,
  input logic [YW-1:0]     cur_y_i,
  input logic [XW-1:0]     dst_x_i,
  input logic [YW-1:0]     dst_y_i,
  input logic [CLS_W-1:0]  class_i,
  input logic              io_i,
  input logic              wrap_x_i,
  input logic              wrap_y_i,
  input logic [OCCV_W-1:0] adapt_occ_i,
  input logic              valid_o,
  input logic [2:0]        port_o,
  input logic [1:0]        vc_o,
  input logic              wrap_x_o,
  input logic              wrap_y_o
);
  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  // R7
  io_no_adapt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && io_i) |=> vc_o != 2'd2);

  // R4
  local_eject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cur_x_i == dst_x_i && cur_y_i == dst_y_i) |=> (port_o == 3'd0 && vc_o == 2'd0));

  // R3
  no_false_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (cur_x_i != dst_x_i || cur_y_i != dst_y_i)) |=> port_o != 3'd0);

  // R8
  x_before_y_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cur_x_i != dst_x_i) |=> !(vc_o != 2'd2 && (port_o == 3'd3 || port_o == 3'd4)));

  // R10
  wrap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wrap_x_i) |=> wrap_x_o);

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!valid_o && port_o == 3'd0 && vc_o == 2'd0);
    end
  end
endmodule

bind torus_route_sel torus_route_sel_chk #(
  .X_SIZE(X_SIZE), .Y_SIZE(Y_SIZE), .NUM_CLASS(NUM_CLASS), .ADAPT_DEPTH(ADAPT_DEPTH),
  .OCC_W(OCC_W), .XW(XW), .YW(YW), .CLS_W(CLS_W), .OCCV_W(OCCV_W)
) u_chk (.*);

// File: tb/torus_route_sel_tb.sv
module torus_route_sel_tb;
  localparam int XS = 4, YS = 4, NC = 4, DEP = 4, OW = 3;
  localparam int OV = 4 * NC * OW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    cur_x_i = '0, cur_y_i = '0, dst_x_i = '0, dst_y_i = '0;
  logic [1:0]    class_i = '0;
  logic          io_i = 1'b0, wrap_x_i = 1'b0, wrap_y_i = 1'b0;
  logic [OV-1:0] adapt_occ_i = '0;
  logic          valid_o, wrap_x_o, wrap_y_o;
  logic [2:0]    port_o;
  logic [1:0]    vc_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  torus_route_sel u_dut (.*);

  function automatic logic [OV-1:0] occ_set(logic [OV-1:0] v, int d, int c, int val);
    logic [OV-1:0] r = v;
    r[(d * NC + c) * OW +: OW] = OW'(val);
    return r;
  endfunction

  // expected {port, vc, wx, wy}
  function automatic logic [6:0] model(int cx, int cy, int dx, int dy, int c, bit io,
                                       bit wx, bit wy, logic [OV-1:0] occ);
    int fx = (dx - cx + XS) % XS;
    int fy = (dy - cy + YS) % YS;
    int px = (2 * fx <= XS) ? 1 : 2;
    int py = (2 * fy <= YS) ? 3 : 4;
    int ox = int'(occ[((px - 1) * NC + c) * OW +: OW]);
    int oy = int'(occ[((py - 1) * NC + c) * OW +: OW]);
    bit ax = (fx != 0) && ox < DEP;
    bit ay = (fy != 0) && oy < DEP;
    int port, vc;
    bit crossx = (px == 1) ? (cx == XS - 1) : (cx == 0);
    bit crossy = (py == 3) ? (cy == YS - 1) : (cy == 0);
    if (fx == 0 && fy == 0) return {3'd0, 2'd0, wx, wy};
    if (!io && (ax || ay)) begin
      vc = 2;
      port = (ay && (!ax || oy < ox)) ? py : px;
    end else if (fx != 0) begin
      port = px; vc = (wx || crossx) ? 1 : 0;
    end else begin
      port = py; vc = (wy || crossy) ? 1 : 0;
    end
    if (port <= 2) return {3'(port), 2'(vc), wx | crossx, wy};
    return {3'(port), 2'(vc), wx, wy | crossy};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b (valid,port,vc,wx,wy)", tag, got, exp);
    end
  endtask

  task automatic route(string tag, int cx, int cy, int dx, int dy, int c, bit io,
                       bit wx, bit wy, logic [OV-1:0] occ);
    cur_x_i = 2'(cx); cur_y_i = 2'(cy); dst_x_i = 2'(dx); dst_y_i = 2'(dy);
    class_i = 2'(c); io_i = io; wrap_x_i = wx; wrap_y_i = wy; adapt_occ_i = occ;
    valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, {valid_o, port_o, vc_o, wrap_x_o, wrap_y_o},
          {1'b1, model(cx, cy, dx, dy, c, io, wx, wy, occ)});
  endtask

  function automatic logic [OV-1:0] all_full();
    logic [OV-1:0] r = '0;
    for (int d = 0; d < 4; d++)
      for (int c = 0; c < NC; c++) r = occ_set(r, d, c, DEP);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [OV-1:0] o;
    int seed;
    seed = $urandom(32'h1F2E3D);
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 reset", {valid_o, port_o, vc_o, wrap_x_o, wrap_y_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    route("R4 local", 2, 1, 2, 1, 0, 0, 1, 1, '0);
    route("R3 tie positive", 0, 0, 2, 0, 1, 0, 0, 0, '0);
    route("R3 negative", 2, 0, 1, 0, 1, 0, 0, 0, '0);
    route("R9 west wrap escape", 0, 0, 3, 0, 0, 0, 0, 0, all_full());
    route("R10 adaptive east wrap", 3, 2, 0, 2, 2, 0, 0, 0, '0);
    o = occ_set('0, 0, 1, 2); o = occ_set(o, 2, 1, 1);
    route("R6 lower occ wins", 0, 0, 1, 1, 1, 0, 0, 0, o);
    o = occ_set('0, 0, 1, 1); o = occ_set(o, 2, 1, 1);
    route("R6 tie picks X", 0, 0, 1, 1, 1, 0, 0, 0, o);
    o = occ_set('0, 0, 1, DEP);
    route("R5 full X uses Y", 0, 0, 1, 1, 1, 0, 0, 0, o);
    route("R7 io escape", 1, 1, 2, 2, 3, 1, 0, 0, '0);
    route("R8 escape X first", 1, 1, 2, 3, 0, 0, 0, 0, all_full());
    route("R9 north wrap VC1", 1, 3, 1, 0, 0, 0, 0, 0, all_full());
    route("R9 prior wrap VC1", 1, 1, 2, 1, 0, 0, 1, 0, all_full());
    route("R9 no wrap VC0", 1, 1, 1, 2, 0, 0, 0, 0, all_full());
    o = all_full();
    for (int c = 0; c < NC; c++) if (c != 2) o = o; else o = occ_set(o, 0, 2, 0);
    route("R11 other classes full", 1, 1, 2, 1, 2, 0, 0, 0, o);
    o = occ_set('0, 0, 0, DEP); o = occ_set(o, 0, 2, DEP);
    route("R11 only own class counts", 1, 1, 2, 1, 1, 0, 0, 0, o);

    valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    // R2
    check("R2 valid drop", {7'd0, valid_o}, 8'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [OV-1:0] r = '0;
      for (int d = 0; d < 4; d++)
        for (int c = 0; c < NC; c++) r = occ_set(r, d, c, $urandom_range(0, DEP));
      route("R3 R5 R6 R8 R9 R10 random",
            $urandom_range(0, XS - 1), $urandom_range(0, YS - 1),
            $urandom_range(0, XS - 1), $urandom_range(0, YS - 1),
            $urandom_range(0, NC - 1), ($urandom_range(0, 7) == 0),
            $urandom_range(0, 1), $urandom_range(0, 1), r);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule